// File: doc/BRIEF.md
# Closed-Page SDRAM Access Sequencer

This block turns word-oriented bus requests into SDRAM command sequences under a strict closed-page policy. Each accepted request opens one row with ACTIVATE, moves one or several words with READ or WRITE commands, and closes the bank with PRE-CHARGE before the next request can be accepted. Bursts move a fixed number of consecutive words with one command per cycle and no idle cycles between them. The column address rises by one for each word.

When error correction is switched on, a single write that does not cover the whole word is turned into a read-modify-write inside one activation. The old word is read back and handed to an external merge stage. That stage returns the merged word, which is then written back in full. Before that WRITE the data mask is raised for two cycles, so that any trailing read data the device still drives is suppressed. The check-bit arithmetic and refresh arbitration belong to neighbouring blocks.

Top module: `sdram_seq`

## Requirements
- R1: After reset the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), the data mask is 0, the data bus is not driven, `bus_rdy` is low and `req_ready` is high.
- R2: An access issues ACTIVATE (0011) with the row and bank, then NOP, and the first READ (0101) or WRITE (0100) exactly CL cycles after ACTIVATE, where CL is 3 when `cfg_cas3` is 1 and 2 otherwise.
- R3: Read data on `sd_dq_in` is taken CL cycles after each READ and is presented on `bus_rdata` with a one-cycle `bus_rdy` pulse in the cycle after that, once per word.
- R4: A burst request (`req_burst`=1) issues BURST_LEN (default 8) READ or WRITE commands in consecutive cycles, with the column rising by one per word; a single request issues one.
- R5: Each access ends with exactly one PRE-CHARGE (0010) to the same bank: one cycle after the last READ, or TWR (default 2) cycles after the last WRITE; no ACTIVATE is issued while a row is open.
- R6: The column is `req_addr[14:2]`, the bank is `req_addr[16:15]` and the row is `req_addr[29:17]`; the row is driven on `sd_a` with ACTIVATE and the column with READ or WRITE.
- R7: With error correction off, a single write drives `sd_dqm` = ~`req_be` with its WRITE; bursts and reads drive mask 0.
- R8: With error correction on, a single write with `req_be` not 1111 issues ACTIVATE, one READ, one WRITE exactly CL+2 cycles after that READ with mask 0 and the merged word on `sd_dq_out`, then PRE-CHARGE.
- R9: In a read-modify-write, `sd_dqm` is 1111 in both cycles before its WRITE.
- R10: A write with `req_be` = 1111 never takes the read-modify-write path, even with error correction on.
- R11: `req_ready` is high only while no access is in progress; back-to-back requests see the next ACTIVATE exactly TRP (default 2) cycles after the previous PRE-CHARGE.
- R12: For writes `bus_rdy` is high in the cycle before each WRITE, and `bus_wdata` is consumed at the end of that cycle; the internal read of a read-modify-write raises no `bus_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cfg_ecc_en | input | 1 | Enables read-modify-write for sub-word single writes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | 1 burst of BURST_LEN words, 0 single word |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte enables for single writes |
| bus_wdata | input | DATA_W | Write data for the current word |
| bus_rdata | output | DATA_W | Read data |
| bus_rdy | output | 1 | One pulse per transferred word |
| rmw_old_data | output | DATA_W | Word read back during read-modify-write |
| rmw_be | output | DATA_W/8 | Byte enables of the pending read-modify-write |
| rmw_merged | input | DATA_W | Merged word from the external merge stage |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | max(ROW_W,COL_W) | Row or column address |
| sd_dqm | output | DATA_W/8 | Data mask |
| sd_dq_out | output | DATA_W | Write data to the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | DATA_W | Read data from the device |

## Verification
The read-back of a read-modify-write and the bus handshake for its write word fall in the same cycle. The captured old word shows up exactly when `bus_rdy` must rise for the WRITE that follows. This is provoked with sub-word single writes under error correction at both CAS latencies. It is judged by counting exactly one `bus_rdy` pulse and by checking that the written word is the byte-wise merge of the old word and the bus word. A second collision, the closing PRE-CHARGE of one access against the acceptance of the next, is provoked with back-to-back reads. There the ACTIVATE spacing is checked to the cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_ACT = 4'b0011,
      CMD_RD  = 4'b0101,
      CMD_WR  = 4'b0100,
      CMD_PRE = 4'b0010
   } sd_cmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ACTW,
      S_XFER,
      S_RMWW,
      S_RECOV,
      S_PREW
   } seq_st_e;
endpackage

// File: rtl/sdram_seq_addr.sv
module sdram_seq_addr #(
   parameter int ADDR_W = 32,
   parameter int ROW_W  = 13,
   parameter int COL_W  = 13,
   parameter int BANK_W = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic [BANK_W-1:0] bank
);
   localparam int COL_LSB  = 2;
   localparam int BANK_LSB = COL_LSB + COL_W;
   localparam int ROW_LSB  = BANK_LSB + BANK_W;

   always_comb begin
      col  = addr[COL_LSB  +: COL_W];
      bank = addr[BANK_LSB +: BANK_W];
      row  = addr[ROW_LSB  +: ROW_W];
   end
endmodule

// File: rtl/sdram_seq_rdpipe.sv
module sdram_seq_rdpipe #(
   parameter int DATA_W = 32,
   parameter int CL_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cas3,
   input  logic              rd_issued,
   input  logic              rd_is_rmw,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              rd_rmw
);
   logic [CL_MAX-1:0] vld_sr;
   logic [CL_MAX-1:0] rmw_sr;
   logic              cap;
   logic              cap_rmw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_sr[0] <= 1'b0;
         rmw_sr[0] <= 1'b0;
      end else begin
         vld_sr[0] <= rd_issued;
         rmw_sr[0] <= rd_issued & rd_is_rmw;
      end
   end

   for (genvar k = 1; k < CL_MAX; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_sr[k] <= 1'b0;
            rmw_sr[k] <= 1'b0;
         end else begin
            vld_sr[k] <= vld_sr[k-1];
            rmw_sr[k] <= rmw_sr[k-1];
         end
      end
   end

   // stage k holds a READ issued k+1 cycles ago; sample at latency CL
   always_comb begin
      cap     = cas3 ? vld_sr[2] : vld_sr[1];
      cap_rmw = cas3 ? rmw_sr[2] : rmw_sr[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_rmw  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_vld <= cap;
         rd_rmw <= cap & cap_rmw;
         if (cap) rd_data <= dq_in;
      end
   end
endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
   import sdram_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ROW_W     = 13,
   parameter int COL_W     = 13,
   parameter int BANK_W    = 2,
   parameter int BURST_LEN = 8,
   parameter int TWR       = 2,
   parameter int TRP       = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cas3,
   input  logic                     ecc_en,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic                     req_burst,
   input  logic [DATA_W/8-1:0]      req_be,
   input  logic [ROW_W-1:0]         in_row,
   input  logic [COL_W-1:0]         in_col,
   input  logic [BANK_W-1:0]        in_bank,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [DATA_W-1:0]        merged,
   output logic                     wr_rdy,
   output logic [3:0]               cmd_q,
   output logic [BANK_W-1:0]        ba_q,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] a_q,
   output logic [DATA_W/8-1:0]      dqm_q,
   output logic [DATA_W-1:0]        dq_q,
   output logic                     oe_q,
   output logic                     rd_rmw_q,
   output logic [DATA_W/8-1:0]      rmw_be
);
   localparam int A_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int BE_W  = DATA_W / 8;
   localparam int IDX_W = $clog2(BURST_LEN + 1);
   localparam int CNT_W = $clog2(TWR + TRP + 8);

   seq_st_e           st;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_idx;
   logic              op_wr;
   logic              op_rmw;
   logic [ROW_W-1:0]  l_row;
   logic [COL_W-1:0]  l_col;
   logic [BANK_W-1:0] l_bank;
   logic [BE_W-1:0]   l_be;

   sd_cmd_e           nxt_cmd;
   logic [A_W-1:0]    nxt_a;
   logic [BANK_W-1:0] nxt_ba;
   logic [BE_W-1:0]   nxt_dqm;
   logic              use_merged;
   logic [COL_W-1:0]  col_now;
   logic [CNT_W-1:0]  cl_m1;
   logic [CNT_W-1:0]  cl_p1;
   logic              take;

   assign rmw_be = l_be;

   always_comb begin
      cl_m1      = cas3 ? CNT_W'(2) : CNT_W'(1);
      cl_p1      = cas3 ? CNT_W'(4) : CNT_W'(3);
      col_now    = l_col + COL_W'(idx);
      req_ready  = (st == S_IDLE);
      take       = req_ready & req_valid;
      nxt_cmd    = CMD_NOP;
      nxt_a      = '0;
      nxt_ba     = l_bank;
      nxt_dqm    = '0;
      use_merged = 1'b0;
      wr_rdy     = 1'b0;
      unique case (st)
         S_IDLE: begin
            nxt_ba = in_bank;
            if (req_valid) begin
               nxt_cmd = CMD_ACT;
               nxt_a   = A_W'(in_row);
            end
         end
         S_XFER: begin
            nxt_a = A_W'(col_now);
            if (op_wr && !op_rmw) begin
               nxt_cmd = CMD_WR;
               nxt_dqm = ~l_be;
               wr_rdy  = 1'b1;
            end else begin
               nxt_cmd = CMD_RD;
            end
         end
         S_RMWW: begin
            if (cnt == CNT_W'(1) || cnt == CNT_W'(2)) nxt_dqm = '1;
            if (cnt == '0) begin
               nxt_cmd    = CMD_WR;
               nxt_a      = A_W'(l_col);
               use_merged = 1'b1;
               wr_rdy     = 1'b1;
            end
         end
         S_RECOV: begin
            if (cnt == '0) nxt_cmd = CMD_PRE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= CMD_NOP;
         ba_q     <= '0;
         a_q      <= '0;
         dqm_q    <= '0;
         dq_q     <= '0;
         oe_q     <= 1'b0;
         rd_rmw_q <= 1'b0;
      end else begin
         cmd_q    <= nxt_cmd;
         ba_q     <= nxt_ba;
         a_q      <= nxt_a;
         dqm_q    <= nxt_dqm;
         oe_q     <= (nxt_cmd == CMD_WR);
         rd_rmw_q <= (nxt_cmd == CMD_RD) & op_rmw;
         if (nxt_cmd == CMD_WR) dq_q <= use_merged ? merged : wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         idx      <= '0;
         last_idx <= '0;
         op_wr    <= 1'b0;
         op_rmw   <= 1'b0;
         l_row    <= '0;
         l_col    <= '0;
         l_bank   <= '0;
         l_be     <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (take) begin
               st       <= S_ACTW;
               cnt      <= cl_m1;
               idx      <= '0;
               last_idx <= req_burst ? IDX_W'(BURST_LEN - 1) : '0;
               op_wr    <= req_write;
               op_rmw   <= ecc_en & req_write & ~req_burst & (req_be != '1);
               l_row    <= in_row;
               l_col    <= in_col;
               l_bank   <= in_bank;
               l_be     <= (req_write & ~req_burst) ? req_be : '1;
            end
            S_ACTW: begin
               if (cnt == CNT_W'(1)) st <= S_XFER;
               else cnt <= cnt - 1'b1;
            end
            S_XFER: begin
               if (op_rmw) begin
                  st  <= S_RMWW;
                  cnt <= cl_p1;
               end else if (idx == last_idx) begin
                  st  <= S_RECOV;
                  cnt <= op_wr ? CNT_W'(TWR - 1) : '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_RMWW: begin
               if (cnt == '0) begin
                  st  <= S_RECOV;
                  cnt <= CNT_W'(TWR - 1);
               end else cnt <= cnt - 1'b1;
            end
            S_RECOV: begin
               if (cnt == '0) begin
                  st  <= S_PREW;
                  cnt <= CNT_W'(TRP - 2);
               end else cnt <= cnt - 1'b1;
            end
            S_PREW: begin
               if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
   import sdram_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int ROW_W     = 13,
   parameter int COL_W     = 13,
   parameter int BANK_W    = 2,
   parameter int BURST_LEN = 8,
   parameter int TWR       = 2,
   parameter int TRP       = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_cas3,
   input  logic                     cfg_ecc_en,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic                     req_burst,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W/8-1:0]      req_be,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     bus_rdy,
   output logic [DATA_W-1:0]        rmw_old_data,
   output logic [DATA_W/8-1:0]      rmw_be,
   input  logic [DATA_W-1:0]        rmw_merged,
   output logic                     sd_cs_n,
   output logic                     sd_ras_n,
   output logic                     sd_cas_n,
   output logic                     sd_we_n,
   output logic [BANK_W-1:0]        sd_ba,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] sd_a,
   output logic [DATA_W/8-1:0]      sd_dqm,
   output logic [DATA_W-1:0]        sd_dq_out,
   output logic                     sd_dq_oe,
   input  logic [DATA_W-1:0]        sd_dq_in
);
   localparam int CL_MAX  = 3;
   localparam int ROW_TOP = 2 + COL_W + BANK_W + ROW_W;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("sdram_seq: DATA_W must be a multiple of 8");
   end
   if (TRP < 2 || TWR < 1) begin : g_bad_timing
      $error("sdram_seq: TRP must be at least 2 and TWR at least 1");
   end
   if (BURST_LEN < 1 || BURST_LEN > (1 << COL_W)) begin : g_bad_burst
      $error("sdram_seq: BURST_LEN out of range");
   end
   if (ADDR_W < ROW_TOP) begin : g_bad_addr
      $error("sdram_seq: ADDR_W too narrow for row, bank and column");
   end

   logic [ROW_W-1:0]  m_row;
   logic [COL_W-1:0]  m_col;
   logic [BANK_W-1:0] m_bank;
   logic [3:0]        cmd_q;
   logic              wr_rdy;
   logic              rd_rmw_q;
   logic              rd_vld;
   logic              rd_rmw;
   logic [DATA_W-1:0] rd_data;

   sdram_seq_addr #(
      .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)
   ) u_addr (
      .addr(req_addr), .row(m_row), .col(m_col), .bank(m_bank)
   );

   sdram_seq_fsm #(
      .DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W),
      .BURST_LEN(BURST_LEN), .TWR(TWR), .TRP(TRP)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cas3(cfg_cas3), .ecc_en(cfg_ecc_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_burst(req_burst), .req_be(req_be),
      .in_row(m_row), .in_col(m_col), .in_bank(m_bank),
      .wdata(bus_wdata), .merged(rmw_merged), .wr_rdy(wr_rdy),
      .cmd_q(cmd_q), .ba_q(sd_ba), .a_q(sd_a), .dqm_q(sd_dqm),
      .dq_q(sd_dq_out), .oe_q(sd_dq_oe), .rd_rmw_q(rd_rmw_q), .rmw_be(rmw_be)
   );

   sdram_seq_rdpipe #(
      .DATA_W(DATA_W), .CL_MAX(CL_MAX)
   ) u_rdpipe (
      .clk(clk), .rst_n(rst_n), .cas3(cfg_cas3),
      .rd_issued(cmd_q == CMD_RD), .rd_is_rmw(rd_rmw_q), .dq_in(sd_dq_in),
      .rd_data(rd_data), .rd_vld(rd_vld), .rd_rmw(rd_rmw)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign bus_rdata    = rd_data;
   assign rmw_old_data = rd_data;
   assign bus_rdy      = wr_rdy | (rd_vld & ~rd_rmw);
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
   import sdram_seq_pkg::*;
#(
   parameter int BE_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [3:0]      sd_cmd,
   input logic [BE_W-1:0] sd_dqm,
   input logic            bus_rdy,
   input logic            req_ready
);
   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) open_q <= 1'b0;
      else if (sd_cmd == CMD_ACT) open_q <= 1'b1;
      else if (sd_cmd == CMD_PRE) open_q <= 1'b0;
   end

   p_act_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_ACT) |-> !open_q);

   p_rw_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_RD || sd_cmd == CMD_WR) |-> open_q);

   p_act_then_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_ACT) |=> (sd_cmd == CMD_NOP));

   p_ready_closed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !open_q);

   p_rdy_feeds_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WR) |-> $past(bus_rdy));

   p_mask_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WR && $past(sd_dqm) == '1) |-> ($past(sd_dqm, 2) == '1));
endmodule

bind sdram_seq sdram_seq_chk #(.BE_W(DATA_W / 8)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .sd_cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
   .sd_dqm(sd_dqm), .bus_rdy(bus_rdy), .req_ready(req_ready)
);

// File: tb/sdram_seq_tb_top.sv
module sdram_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR = 4'b0100, C_PRE = 4'b0010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cas3 = 1'b0, ecc = 1'b0;
   logic        req_valid = 1'b0, req_ready, req_write = 1'b0, req_burst = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_be = 4'hF;
   logic [31:0] bus_wdata, bus_rdata, rmw_old, rmw_merged, dq_out;
   logic [31:0] dq_in = '0;
   logic        bus_rdy, dq_oe;
   logic [3:0]  rmw_be, dqm;
   logic        cs_n, ras_n, cas_n, we_n;
   logic [1:0]  ba;
   logic [12:0] a;

   int checks = 0, errors = 0, cyc = 0, widx = 0;
   bit inc_pend = 0;
   logic [31:0] mem [64];
   bit          slot_v [8];
   int          slot_k [8];
   logic [3:0]  dqm_p1 = '0, dqm_p2 = '0;
   int          n_ev = 0, n_rdy = 0;
   logic [3:0]  ev_cmd [32];
   int          ev_cyc [32];
   logic [12:0] ev_a [32];
   logic [1:0]  ev_ba [32];
   logic [31:0] ev_dq [32];
   logic [3:0]  ev_dqm [32], ev_p1 [32], ev_p2 [32];
   int          rdy_cyc [16];
   logic [31:0] rdy_dat [16];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] wpat(int i);
      return 32'hC0DE_0000 + 32'(i) * 32'h0000_0111;
   endfunction
   function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
      return r;
   endfunction
   function automatic logic [31:0] mk(int row, int bank, int col);
      return (32'(row) << 17) | (32'(bank) << 15) | (32'(col) << 2);
   endfunction
   function automatic int key(int bank, int col);
      return bank * 16 + (col % 16);
   endfunction

   assign bus_wdata  = wpat(widx);
   assign rmw_merged = merge(rmw_old, bus_wdata, rmw_be);

   sdram_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_cas3(cas3), .cfg_ecc_en(ecc),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_burst(req_burst), .req_addr(req_addr), .req_be(req_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
      .rmw_old_data(rmw_old), .rmw_be(rmw_be), .rmw_merged(rmw_merged),
      .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
      .sd_ba(ba), .sd_a(a), .sd_dqm(dqm), .sd_dq_out(dq_out),
      .sd_dq_oe(dq_oe), .sd_dq_in(dq_in)
   );

   // device model and pin log, sampled mid-cycle
   always @(negedge clk) begin
      logic [3:0] c;
      if (inc_pend) begin widx++; inc_pend = 0; end
      dq_in = slot_v[cyc % 8] ? mem[slot_k[cyc % 8]] : 32'hDEAD_BEEF;
      slot_v[cyc % 8] = 0;
      c = {cs_n, ras_n, cas_n, we_n};
      if (c != C_NOP && n_ev < 32) begin
         ev_cmd[n_ev] = c; ev_cyc[n_ev] = cyc; ev_a[n_ev] = a; ev_ba[n_ev] = ba;
         ev_dq[n_ev] = dq_out; ev_dqm[n_ev] = dqm; ev_p1[n_ev] = dqm_p1; ev_p2[n_ev] = dqm_p2;
         n_ev++;
      end
      if (c == C_RD) begin
         slot_v[(cyc + (cas3 ? 3 : 2)) % 8] = 1;
         slot_k[(cyc + (cas3 ? 3 : 2)) % 8] = key(int'(ba), int'(a));
      end
      if (c == C_WR)
         for (int b = 0; b < 4; b++)
            if (!dqm[b]) mem[key(int'(ba), int'(a))][8*b +: 8] = dq_out[8*b +: 8];
      if (bus_rdy) begin
         if (n_rdy < 16) begin rdy_cyc[n_rdy] = cyc; rdy_dat[n_rdy] = bus_rdata; end
         n_rdy++;
         inc_pend = 1;
      end
      dqm_p2 = dqm_p1; dqm_p1 = dqm;
   end

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clr();
      n_ev = 0; n_rdy = 0; widx = 0;
   endtask

   task automatic issue(bit wr, bit burst, logic [31:0] ad, logic [3:0] be);
      @(negedge clk);
      req_write = wr; req_burst = burst; req_addr = ad; req_be = be; req_valid = 1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 cmd", {28'd0, cs_n, ras_n, cas_n, we_n}, C_NOP);
      chk(!dq_oe && dqm == 0 && !bus_rdy, "R1 oe/dqm/rdy", {dq_oe, dqm, bus_rdy}, 0);
      chk(req_ready, "R1 ready", req_ready, 1);
   endtask

   task automatic t_read(bit c3, bit burst, int row, int bk, int col);
      int cl = c3 ? 3 : 2, n = burst ? 8 : 1;
      cas3 = c3; ecc = 0; clr();
      issue(0, burst, mk(row, bk, col), 4'hF);
      repeat (30) @(negedge clk);
      chk(n_ev == n + 2, "R4 command count", n_ev, n + 2);
      chk(ev_cmd[0] == C_ACT && ev_a[0] == 13'(row) && ev_ba[0] == 2'(bk),
          "R6 act row/bank", {ev_a[0], ev_ba[0]}, {13'(row), 2'(bk)});
      for (int i = 0; i < n; i++) begin
         chk(ev_cmd[1+i] == C_RD && ev_cyc[1+i] == ev_cyc[0] + cl + i,
             "R2 R4 read timing", ev_cyc[1+i] - ev_cyc[0], cl + i);
         chk(ev_a[1+i] == 13'(col + i), "R6 column", ev_a[1+i], col + i);
         chk(rdy_cyc[i] == ev_cyc[1+i] + cl + 1, "R3 rdy timing", rdy_cyc[i] - ev_cyc[1+i], cl + 1);
         chk(rdy_dat[i] == mem[key(bk, col + i)], "R3 read data", rdy_dat[i], mem[key(bk, col + i)]);
      end
      chk(n_rdy == n, "R3 rdy count", n_rdy, n);
      chk(ev_cmd[n+1] == C_PRE && ev_cyc[n+1] == ev_cyc[n] + 1 && ev_ba[n+1] == 2'(bk),
          "R5 precharge after read", ev_cyc[n+1] - ev_cyc[n], 1);
   endtask

   task automatic t_wburst(bit c3, int row, int bk, int col);
      int cl = c3 ? 3 : 2;
      cas3 = c3; ecc = 1; clr();
      issue(1, 1, mk(row, bk, col), 4'hF);
      repeat (30) @(negedge clk);
      chk(n_ev == 10, "R4 write burst count", n_ev, 10);
      for (int i = 0; i < 8; i++) begin
         chk(ev_cmd[1+i] == C_WR && ev_cyc[1+i] == ev_cyc[0] + cl + i,
             "R4 gapless write", ev_cyc[1+i] - ev_cyc[0], cl + i);
         chk(ev_dq[1+i] == wpat(i) && ev_dqm[1+i] == 0, "R7 burst data", ev_dq[1+i], wpat(i));
         chk(rdy_cyc[i] == ev_cyc[1+i] - 1, "R12 rdy before write", rdy_cyc[i], ev_cyc[1+i] - 1);
      end
      chk(ev_cmd[9] == C_PRE && ev_cyc[9] == ev_cyc[8] + 2, "R5 write recovery",
          ev_cyc[9] - ev_cyc[8], 2);
   endtask

   task automatic t_sub_plain(int bk, int col, logic [3:0] be);
      logic [31:0] old;
      cas3 = 0; ecc = 0; clr();
      old = mem[key(bk, col)];
      issue(1, 0, mk(3, bk, col), be);
      repeat (20) @(negedge clk);
      chk(n_ev == 3 && ev_cmd[1] == C_WR, "R7 plain single write", n_ev, 3);
      chk(ev_dqm[1] == ~be, "R7 mask", ev_dqm[1], ~be);
      chk(mem[key(bk, col)] == merge(old, wpat(0), be), "R7 stored bytes",
          mem[key(bk, col)], merge(old, wpat(0), be));
   endtask

   task automatic t_rmw(bit c3, int bk, int col, logic [3:0] be);
      int cl = c3 ? 3 : 2;
      logic [31:0] exp;
      cas3 = c3; ecc = 1; clr();
      exp = merge(mem[key(bk, col)], wpat(0), be);
      issue(1, 0, mk(7, bk, col), be);
      repeat (30) @(negedge clk);
      chk(n_ev == 4 && ev_cmd[1] == C_RD && ev_cmd[2] == C_WR && ev_cmd[3] == C_PRE,
          "R8 rmw sequence", n_ev, 4);
      chk(ev_cyc[1] == ev_cyc[0] + cl, "R2 rmw read timing", ev_cyc[1] - ev_cyc[0], cl);
      chk(ev_cyc[2] == ev_cyc[1] + cl + 2, "R8 rmw write timing", ev_cyc[2] - ev_cyc[1], cl + 2);
      chk(ev_dq[2] == exp && ev_dqm[2] == 0, "R8 merged word", ev_dq[2], exp);
      chk(ev_p1[2] == 4'hF && ev_p2[2] == 4'hF, "R9 mask raised early", {ev_p2[2], ev_p1[2]}, 8'hFF);
      chk(n_rdy == 1 && rdy_cyc[0] == ev_cyc[2] - 1, "R12 single rdy in rmw", n_rdy, 1);
      chk(ev_cyc[3] == ev_cyc[2] + 2, "R5 rmw precharge", ev_cyc[3] - ev_cyc[2], 2);
   endtask

   task automatic t_full_ecc(int bk, int col);
      cas3 = 0; ecc = 1; clr();
      issue(1, 0, mk(2, bk, col), 4'hF);
      repeat (20) @(negedge clk);
      chk(n_ev == 3 && ev_cmd[1] == C_WR, "R10 full word skips rmw", n_ev, 3);
      chk(mem[key(bk, col)] == wpat(0), "R10 stored word", mem[key(bk, col)], wpat(0));
   endtask

   task automatic t_b2b();
      cas3 = 0; ecc = 0; clr();
      issue(0, 0, mk(1, 0, 1), 4'hF);
      issue(0, 0, mk(2, 1, 2), 4'hF);
      repeat (20) @(negedge clk);
      chk(n_ev == 6 && ev_cmd[3] == C_ACT, "R11 two accesses", n_ev, 6);
      chk(ev_cyc[3] == ev_cyc[2] + 2, "R11 act after precharge", ev_cyc[3] - ev_cyc[2], 2);
   endtask

   initial begin
      for (int k = 0; k < 64; k++) mem[k] = 32'h5A00_0000 + 32'(k) * 32'h0001_0203;
      for (int k = 0; k < 8; k++) slot_v[k] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_read(0, 0, 5, 1, 3);
      t_read(1, 0, 9, 2, 7);
      t_read(0, 1, 4, 0, 4);
      t_wburst(1, 6, 3, 0);
      t_read(1, 1, 6, 3, 0);
      t_sub_plain(1, 12, 4'b0101);
      t_rmw(0, 2, 13, 4'b0010);
      t_rmw(1, 0, 14, 4'b1100);
      t_full_ecc(1, 9);
      t_b2b();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule